// File: doc/BRIEF.md
# LCD Pixel Clock Generator

This block derives the pixel clock of a display controller from a single double-rate clock. A programmable 8-bit divide value sets the pixel period to that value plus two source cycles. A source-select bit picks the source cycle: either the double-rate clock itself, or the base clock, which is half its rate. The base clock is not a separate input. When it is selected, the internal counter advances only on every other double-rate cycle, so the block needs no clock multiplexer.

With the pixel clock, the block produces a one-cycle launch strobe. The strobe marks the pixel-clock edge on which the display timing logic should change its data and control outputs. A polarity bit picks that edge: rising or falling. Changes to the divide value or the source select are held until the next pixel-period boundary, so the block never emits a shortened or stretched pulse.

The block also forms one clock enable per display layer, for base, overlay 1, high-end overlay and cursor. Each enable follows the activity flag of its layer unless that layer's gating-disable bit forces it on. The PWM clock-source choice is passed through as a select output. All configuration inputs are expected to come from a register block whose reset value is zero. None of the inputs or outputs carries a data stream, so there is no valid/ready handshake.

Top module: `lcd_pclk_gen`

## Requirements
- R1: The pixel clock period, measured between rising edges, is (cfg_div + 2) source cycles, for every cfg_div from 0 to 255.
- R2: A source cycle is one clk2x cycle when cfg_src_2x is 1. It is two clk2x cycles when cfg_src_2x is 0.
- R3: Each period starts with a high phase of floor((cfg_div+2)/2) source cycles. The low phase is the rest of the period, so odd ratios have a high phase one source cycle shorter than the low phase.
- R4: launch is high for exactly one clk2x cycle, and only in the cycle where pclk first shows the active edge. With cfg_pol 0 the active edge is the rising edge. With cfg_pol 1 it is the falling edge.
- R5: A new cfg_div or cfg_src_2x value does not affect the period in progress. It takes effect from the next rising edge of pclk.
- R6: layer_clk_en[i] equals layer_active[i] OR cfg_gate_dis[i] at all times. The bit order is 0 base, 1 overlay 1, 2 high-end overlay, 3 cursor.
- R7: pwm_clk_sel equals cfg_pwm_sys: 0 selects the slow clock and 1 selects the system clock.
- R8: While rst_n is low, pclk and launch are 0. After release, pclk rises within two clk2x cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock, the only clock of the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Divide value; ratio is cfg_div + 2 |
| cfg_src_2x | input | 1 | 0: base-rate source cycles, 1: double-rate source cycles |
| cfg_pol | input | 1 | 0: launch at rising edge, 1: launch at falling edge |
| cfg_gate_dis | input | 4 | Per-layer gating disable (1 = clock always on) |
| cfg_pwm_sys | input | 1 | PWM clock choice: 0 slow clock, 1 system clock |
| layer_active | input | 4 | Per-layer activity flags |
| pclk | output | 1 | Pixel clock |
| launch | output | 1 | One-cycle strobe at the active pixel-clock edge |
| layer_clk_en | output | 4 | Per-layer clock enables |
| pwm_clk_sel | output | 1 | PWM clock source select |

## Verification
The divider is swept over the small ratios 2 to 11 and the two largest ratios. Each is tried at both source rates and both polarities. The small ratios separate even from odd high-phase lengths and expose off-by-one errors in the wrap point. The largest ratios catch overflow of the ratio arithmetic. Comparing the two source rates checks that the base setting exactly doubles every interval.

The launch strobe is compared against the observed pixel-clock edges on every cycle, under both polarities. A divide change made partway through a period shows whether the new value waits for the boundary. An exhaustive sweep of the 256 activity/disable pairs covers the layer enables.

// File: rtl/lcdpc_pkg.sv
package lcdpc_pkg;
  localparam int DIV_W      = 8;
  localparam int NUM_LAYERS = 4;

  typedef enum logic {
    SRC_BASE   = 1'b0,
    SRC_DOUBLE = 1'b1
  } src_sel_e;

  typedef enum int {
    LYR_BASE   = 0,
    LYR_OVL1   = 1,
    LYR_HEO    = 2,
    LYR_CURSOR = 3
  } layer_idx_e;
endpackage

// File: rtl/lcdpc_tick.sv
// Source-cycle enable: every clk2x cycle in double-rate mode, every other
// cycle in base mode. The phase restarts at each pixel period boundary.
module lcdpc_tick
  import lcdpc_pkg::*;
(
  input  logic     clk2x,
  input  logic     rst_n,
  input  src_sel_e src_sel,
  input  logic     restart,
  output logic     tick
);
  logic phase_q;

  assign tick = (src_sel == SRC_DOUBLE) || phase_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (restart) phase_q <= 1'b0;
    else              phase_q <= ~phase_q;
  end
endmodule

// File: rtl/lcdpc_div.sv
// Programmable divider: ratio = div + 2, new settings latched at wrap.
module lcdpc_div
  import lcdpc_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk2x,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cfg_div,
  input  logic         cfg_src_2x,
  input  logic         cfg_pol,
  output logic         pclk,
  output logic         launch,
  output logic         wrap,
  output src_sel_e     src_sel
);
  localparam int CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] ratio_q, ratio_nx;
  logic [CW-1:0] half_nx;
  src_sel_e      src_q, src_nx;
  logic          pclk_q, launch_q;
  logic          pclk_nx, launch_nx;

  always_comb begin
    cnt_nx   = cnt_q;
    ratio_nx = ratio_q;
    src_nx   = src_q;
    wrap     = tick && (cnt_q == ratio_q - CW'(1));
    if (wrap) begin
      cnt_nx   = '0;
      ratio_nx = CW'(cfg_div) + CW'(2);
      src_nx   = cfg_src_2x ? SRC_DOUBLE : SRC_BASE;
    end else if (tick) begin
      cnt_nx = cnt_q + CW'(1);
    end
    half_nx   = ratio_nx >> 1;
    pclk_nx   = (cnt_nx < half_nx);
    launch_nx = tick && (cfg_pol ? (cnt_nx == half_nx) : wrap);
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CW'(1);
      ratio_q  <= CW'(2);
      src_q    <= SRC_BASE;
      pclk_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      ratio_q  <= ratio_nx;
      src_q    <= src_nx;
      pclk_q   <= pclk_nx;
      launch_q <= launch_nx;
    end
  end

  assign pclk    = pclk_q;
  assign launch  = launch_q;
  assign src_sel = src_q;
endmodule

// File: rtl/lcdpc_gate.sv
// Per-layer enable: activity flag, or forced on by the gating-disable bit.
module lcdpc_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] active,
  input  logic [N-1:0] gate_dis,
  output logic [N-1:0] clk_en
);
  for (genvar i = 0; i < N; i++) begin : g_layer
    assign clk_en[i] = active[i] | gate_dis[i];
  end
endmodule

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen
  import lcdpc_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int NL = NUM_LAYERS
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_div,
  input  logic          cfg_src_2x,
  input  logic          cfg_pol,
  input  logic [NL-1:0] cfg_gate_dis,
  input  logic          cfg_pwm_sys,
  input  logic [NL-1:0] layer_active,
  output logic          pclk,
  output logic          launch,
  output logic [NL-1:0] layer_clk_en,
  output logic          pwm_clk_sel
);
  logic     tick, wrap;
  src_sel_e src_sel;

  lcdpc_tick u_tick (
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .restart (wrap),
    .tick    (tick)
  );

  lcdpc_div #(.W(DW)) u_div (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg_div    (cfg_div),
    .cfg_src_2x (cfg_src_2x),
    .cfg_pol    (cfg_pol),
    .pclk       (pclk),
    .launch     (launch),
    .wrap       (wrap),
    .src_sel    (src_sel)
  );

  lcdpc_gate #(.N(NL)) u_gate (
    .active   (layer_active),
    .gate_dis (cfg_gate_dis),
    .clk_en   (layer_clk_en)
  );

  assign pwm_clk_sel = cfg_pwm_sys;
endmodule

// File: rtl/lcdpc_chk.sv
module lcdpc_chk #(
  parameter int DW = 8,
  parameter int NL = 4
) (
  input logic          clk2x,
  input logic          rst_n,
  input logic          cfg_pol,
  input logic          cfg_pwm_sys,
  input logic [NL-1:0] cfg_gate_dis,
  input logic [NL-1:0] layer_active,
  input logic          pclk,
  input logic          launch,
  input logic [NL-1:0] layer_clk_en,
  input logic          pwm_clk_sel
);
  // Longest constant pclk phase: ceil(max ratio / 2) base-rate source cycles.
  localparam int MAX_RATIO = (1 << DW) + 1;
  localparam int MAX_RUN   = ((MAX_RATIO + 1) / 2) * 2;
  localparam int RW        = $clog2(MAX_RUN + 2);

  logic [RW-1:0] run_q;
  logic          pclk_d;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      pclk_d <= 1'b0;
    end else begin
      pclk_d <= pclk;
      if (pclk != pclk_d) run_q <= RW'(1);
      else if (run_q <= RW'(MAX_RUN)) run_q <= run_q + RW'(1);
    end
  end

  assert_phase_bound_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
    run_q <= RW'(MAX_RUN));

  assert_launch_on_edge_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    launch |-> (pclk != $past(pclk)));

  assert_launch_rise_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    ($rose(pclk) && !$past(cfg_pol)) |-> launch);

  assert_launch_fall_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    ($fell(pclk) && $past(cfg_pol)) |-> launch);

  assert_launch_single_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    launch |=> !launch);

  assert_layer_en_R6: assert property (@(posedge clk2x) disable iff (!rst_n)
    (layer_clk_en & ~layer_active) == (cfg_gate_dis & ~layer_active));

  assert_pwm_sel_R7: assert property (@(posedge clk2x) disable iff (!rst_n)
    pwm_clk_sel == cfg_pwm_sys);

  always_comb begin
    if (!rst_n) assert_reset_quiet_R8: assert (!pclk && !launch);
  end
endmodule

bind lcd_pclk_gen lcdpc_chk #(.DW(DW), .NL(NL)) u_chk (
  .clk2x        (clk2x),
  .rst_n        (rst_n),
  .cfg_pol      (cfg_pol),
  .cfg_pwm_sys  (cfg_pwm_sys),
  .cfg_gate_dis (cfg_gate_dis),
  .layer_active (layer_active),
  .pclk         (pclk),
  .launch       (launch),
  .layer_clk_en (layer_clk_en),
  .pwm_clk_sel  (pwm_clk_sel)
);

// File: tb/lcd_pclk_gen_bench.sv
`timescale 1ns/1ps
module lcd_pclk_gen_bench;
  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic       cfg_src_2x = 1'b0;
  logic       cfg_pol = 1'b0;
  logic [3:0] cfg_gate_dis = 4'd0;
  logic       cfg_pwm_sys = 1'b0;
  logic [3:0] layer_active = 4'd0;
  logic       pclk, launch, pwm_clk_sel;
  logic [3:0] layer_clk_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk2x = ~clk2x;

  lcd_pclk_gen u_lcd_pclk_gen (
    .clk2x(clk2x), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_src_2x(cfg_src_2x),
    .cfg_pol(cfg_pol), .cfg_gate_dis(cfg_gate_dis), .cfg_pwm_sys(cfg_pwm_sys),
    .layer_active(layer_active), .pclk(pclk), .launch(launch),
    .layer_clk_en(layer_clk_en), .pwm_clk_sel(pwm_clk_sel)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Launch monitor (R4): strobe must match the observed active edge.
  logic pol_at_edge = 1'b0;
  logic prev_pclk   = 1'b0;
  always @(posedge clk2x) pol_at_edge <= cfg_pol;
  always @(negedge clk2x) begin
    if (rst_n) begin
      logic exp_l;
      exp_l = (pclk != prev_pclk) && (pclk == !pol_at_edge);
      if (exp_l || launch) check("R4", launch, exp_l, "launch strobe");
    end
    prev_pclk <= pclk;
  end

  // Wait for a rising edge, then measure one full period and its high phase.
  task automatic measure(output int per, output int hi,
                         input bit chg = 0, input logic [7:0] nd = 8'd0);
    logic last;
    last = pclk;
    forever begin
      @(negedge clk2x);
      if (pclk && !last) break;
      last = pclk;
    end
    per = 1; hi = 1; last = 1'b1;
    forever begin
      @(negedge clk2x);
      if (chg && per == 2) cfg_div = nd;
      if (pclk && !last) break;
      if (pclk) hi++;
      per++;
      last = pclk;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, c;
    logic [7:0] divs [12] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5,
                              8'd6, 8'd7, 8'd8, 8'd9, 8'd254, 8'd255};
    // R8: reset state
    repeat (3) @(negedge clk2x);
    check("R8", pclk, 0, "pclk in reset");
    check("R8", launch, 0, "launch in reset");
    rst_n = 1'b1;
    c = 0;
    while (!pclk && c < 10) begin @(negedge clk2x); c++; end
    check("R8", (c <= 2) ? 1 : 0, 1, "first rise latency");

    // R1 R2 R3: divider sweep over ratios, both sources and polarities
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 12; k++) begin
          int mult, ratio;
          cfg_src_2x = s[0]; cfg_pol = p[0]; cfg_div = divs[k];
          mult  = s ? 1 : 2;
          ratio = int'(divs[k]) + 2;
          measure(per, hi);
          measure(per, hi);
          check(s ? "R1" : "R2", per, ratio * mult, "period");
          check("R3", hi, (ratio / 2) * mult, "high phase");
        end
      end
    end

    // R5: change divider mid-period, in-flight period keeps old ratio
    cfg_src_2x = 1'b1; cfg_pol = 1'b0; cfg_div = 8'd6;
    measure(per, hi);
    measure(per, hi, 1, 8'd0);
    check("R5", per, 8, "period during change");
    measure(per, hi);
    check("R5", per, 2, "period after change");

    // R6: exhaustive layer enable sweep (0 base,1 ovl1,2 heo,3 cursor)
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 16; d++) begin
        layer_active = a[3:0]; cfg_gate_dis = d[3:0];
        @(negedge clk2x);
        check("R6", int'(layer_clk_en), a | d, "layer enables");
      end
    end

    // R7: PWM clock select both values
    for (int w = 0; w < 2; w++) begin
      cfg_pwm_sys = w[0];
      @(negedge clk2x);
      check("R7", int'(pwm_clk_sel), w, "pwm clock select");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule